// File: doc/BRIEF.md
# Paced Power-Domain Control Register

This block holds one 32-bit control word for an always-on, slow power-management domain. A handoff into a slow domain needs time. So after every write the block accepts, it pulls its ready flag (bit 31 of the read data) low for a fixed number of clock cycles. Any write that arrives during that window is discarded. Reads are combinational and can be made at any time. When the window closes, the flag returns high. If the interrupt enable is high at that moment, a one-cycle completion pulse is raised.

A tamper input freezes the clock-configuration fields. The lock is sticky: once the input has been seen high, those fields keep their values until reset, while the remaining writable fields stay programmable. Setting the sleep-request field raises a level output to the power sequencer. From then on, the block ignores every write until reset.

The pacing is a three-state machine:
- ST_READY: the flag is 1 and writes are accepted. An accepted write moves to ST_BUSY.
- ST_BUSY: the flag is 0 and a counter runs. When the counter expires, the machine goes to ST_HALTED if the stored sleep request is set, and to ST_READY otherwise. Either exit raises the completion event.
- ST_HALTED: the flag is 1, all writes are ignored, and only reset leaves this state.

Top module: `pcr_ctrl_reg`

## Requirements
- R1: After reset the read data is 0x8000_2000, irq_o is 0 and sleep_req_o is 0.
- R2: An accepted write stores only the writable bits. The writable mask is 0x400B_67DB: bits 0, 1, 3, 4, 6, 7, 8, 9, 10, 13, 14, 16, 17, 19 and 30. All other bits read 0, and writing bit 31 does not change the ready flag.
- R3: A write is accepted when the ready flag (bit 31) reads 1 and the block is not halted. From the next cycle the flag reads 0 for exactly BUSY_CYC cycles, then reads 1 again.
- R4: A write presented while the ready flag is 0 leaves bits 30:0 unchanged.
- R5: The read data reflects the current contents in every cycle, including busy cycles.
- R6: While the tamper input is high, an accepted write leaves the locked bits unchanged. The locked mask is 0x000B_0141: bits 0, 6, 8, 16, 17 and 19. The other writable bits still take the written value.
- R7: The lock persists after the tamper input falls and is cleared only by reset.
- R8: irq_o is high for exactly one cycle, the first cycle in which the flag returns to 1 after a busy window, and only while irq_en_i is high.
- R9: An accepted write with bit 1 set drives sleep_req_o high from the next cycle until reset. After the busy window the flag reads 1, but every later write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Current contents; bit 31 is the ready flag |
| tamper_i | input | 1 | Tamper enable; sets the sticky lock |
| irq_en_i | input | 1 | Completion interrupt enable |
| irq_o | output | 1 | One-cycle write-completion pulse |
| sleep_req_o | output | 1 | Level sleep request to the power sequencer |

## Verification
The bench builds the block with BUSY_CYC = 5 rather than the default of 4. This shows the window length follows the parameter and is not a fixed constant. A five-cycle window leaves room to present a second write well inside the busy period, so it can be shown to be dropped before the flag rises. The same window checks that the completion pulse lands on the rising edge of the flag and not one cycle either side. A second reset in mid-run confirms that both the lock and the halted state are cleared.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
    localparam int DW        = 32;
    localparam int RDY_BIT   = 31;
    localparam int SLEEP_BIT = 1;

    // bits that software may change
    localparam logic [DW-1:0] WR_MASK   = 32'h400B_67DB;
    // clock-configuration bits frozen by the tamper lock
    localparam logic [DW-1:0] LOCK_MASK = 32'h000B_0141;
    // storage reset value (ready flag is produced by the pacer)
    localparam logic [DW-1:0] RST_VAL   = 32'h0000_2000;

    typedef enum logic [1:0] {
        ST_READY  = 2'd0,
        ST_BUSY   = 2'd1,
        ST_HALTED = 2'd2
    } pace_state_e;
endpackage

// File: rtl/pcr_pacer.sv
module pcr_pacer
    import pcr_pkg::*;
#(
    parameter int BUSY_CYC = 4,
    localparam int CNT_W   = $clog2(BUSY_CYC) + 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wr_en_i,
    input  logic sleep_q_i,
    output logic accept_o,
    output logic ready_o,
    output logic done_o
);
    pace_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic finish, done_q;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_READY;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            done_q  <= finish;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        finish  = 1'b0;
        unique case (state_q)
            ST_READY: begin
                if (wr_en_i) begin
                    state_d = ST_BUSY;
                    cnt_d   = CNT_W'(BUSY_CYC - 1);
                end
            end
            ST_BUSY: begin
                if (cnt_q == '0) begin
                    finish  = 1'b1;
                    state_d = sleep_q_i ? ST_HALTED : ST_READY;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_HALTED: begin
                state_d = ST_HALTED;
            end
            default: begin
                state_d = ST_READY;
            end
        endcase
    end

    // outputs
    always_comb begin
        accept_o = (state_q == ST_READY) && wr_en_i;
        ready_o  = (state_q != ST_BUSY);
        done_o   = done_q;
    end
endmodule

// File: rtl/pcr_lock.sv
module pcr_lock (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tamper_i,
    output logic lock_q_o,
    output logic lock_eff_o
);
    logic lock_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lock_q <= 1'b0;
        else         lock_q <= lock_q | tamper_i;
    end

    assign lock_q_o   = lock_q;
    assign lock_eff_o = lock_q | tamper_i;
endmodule

// File: rtl/pcr_store.sv
module pcr_store
    import pcr_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          accept_i,
    input  logic          lock_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-2:0] q_o
);
    logic unused_wbits;
    assign unused_wbits = ^(wdata_i & ~WR_MASK);

    for (genvar i = 0; i < DW - 1; i++) begin : g_bit
        if (WR_MASK[i]) begin : g_rw
            logic bit_q;
            logic frozen;
            assign frozen = LOCK_MASK[i] ? lock_i : 1'b0;
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)                bit_q <= RST_VAL[i];
                else if (accept_i && !frozen) bit_q <= wdata_i[i];
            end
            assign q_o[i] = bit_q;
        end else begin : g_rsv
            assign q_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/pcr_ctrl_reg.sv
module pcr_ctrl_reg
    import pcr_pkg::*;
#(
    parameter int BUSY_CYC = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [DW-1:0] rd_data_o,
    input  logic          tamper_i,
    input  logic          irq_en_i,
    output logic          irq_o,
    output logic          sleep_req_o
);
    logic accept, ready, done;
    logic lock_q, lock_eff;
    logic [DW-2:0] store_q;

    pcr_pacer #(.BUSY_CYC(BUSY_CYC)) u_pacer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .sleep_q_i (store_q[SLEEP_BIT]),
        .accept_o  (accept),
        .ready_o   (ready),
        .done_o    (done)
    );

    pcr_lock u_lock (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tamper_i   (tamper_i),
        .lock_q_o   (lock_q),
        .lock_eff_o (lock_eff)
    );

    pcr_store u_store (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .accept_i (accept),
        .lock_i   (lock_eff),
        .wdata_i  (wr_data_i),
        .q_o      (store_q)
    );

    assign rd_data_o   = {ready, store_q};
    assign irq_o       = done & irq_en_i;
    assign sleep_req_o = store_q[SLEEP_BIT];
endmodule

// File: rtl/pcr_ctrl_reg_chk.sv
module pcr_ctrl_reg_chk
    import pcr_pkg::*;
#(
    parameter int BUSY_CYC = 4
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          wr_en_i,
    input logic [DW-1:0] rd_data_o,
    input logic          tamper_i,
    input logic          irq_en_i,
    input logic          irq_o,
    input logic          sleep_req_o,
    input logic          lock_q
);
    logic ready, ready_d;
    int   low_cnt;

    assign ready = rd_data_o[RDY_BIT];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ready_d <= 1'b1;
            low_cnt <= 0;
        end else begin
            ready_d <= ready;
            low_cnt <= ready ? 0 : low_cnt + 1;
        end
    end

    assert_busy_after_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && ready && !sleep_req_o) |=> !rd_data_o[RDY_BIT]);

    assert_busy_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready && !ready_d) |-> (low_cnt == BUSY_CYC));

    assert_drop_when_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !ready) |=> (rd_data_o[DW-2:0] == $past(rd_data_o[DW-2:0])));

    assert_lock_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tamper_i |=> ((rd_data_o & LOCK_MASK) == ($past(rd_data_o) & LOCK_MASK)));

    assert_lock_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_q |=> lock_q);

    assert_irq_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (ready && !ready_d && irq_en_i));

    assert_irq_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |=> !irq_o);

    assert_sleep_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sleep_req_o |=> (sleep_req_o && $stable(rd_data_o[DW-2:0])));
endmodule

bind pcr_ctrl_reg pcr_ctrl_reg_chk #(.BUSY_CYC(BUSY_CYC)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .rd_data_o   (rd_data_o),
    .tamper_i    (tamper_i),
    .irq_en_i    (irq_en_i),
    .irq_o       (irq_o),
    .sleep_req_o (sleep_req_o),
    .lock_q      (lock_q)
);

// File: tb/sim_pcr_ctrl_reg.sv
module sim_pcr_ctrl_reg;
    localparam int BC = 5;
    localparam logic [31:0] WMASK = 32'h400B_67DB;
    localparam logic [31:0] LMASK = 32'h000B_0141;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        tamper = 1'b0;
    logic        irq_en = 1'b0;
    logic        irq;
    logic        sleep;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit ended = 0;

    always #10 clk = ~clk;

    pcr_ctrl_reg #(.BUSY_CYC(BC)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd_data), .tamper_i(tamper), .irq_en_i(irq_en),
        .irq_o(irq), .sleep_req_o(sleep)
    );

    // behavioural reference model
    logic [31:0] m_val;
    int          m_left;
    bit          m_lock, m_halt, m_done;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_val = 32'h0000_2000; m_left = 0;
            m_lock = 0; m_halt = 0; m_done = 0;
        end else begin
            logic [31:0] nv;
            bit lk;
            lk = m_lock || tamper;
            m_done = (m_left == 1);
            if (wr_en && m_left == 0 && !m_halt) begin
                nv = wr_data & WMASK;
                if (lk) nv = (nv & ~LMASK) | (m_val & LMASK);
                m_val = nv;
                m_left = BC;
                if (nv[1]) m_halt = 1;
            end else if (m_left > 0) begin
                m_left = m_left - 1;
            end
            if (tamper) m_lock = 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            chk("R5 contents", {1'b0, rd_data[30:0]}, {1'b0, m_val[30:0]});
            chk("R3 ready flag", {31'b0, rd_data[31]}, {31'b0, (m_left == 0)});
            chk("R8 interrupt", {31'b0, irq}, {31'b0, m_done && irq_en});
            chk("R9 sleep", {31'b0, sleep}, {31'b0, m_val[1]});
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !ended) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    task automatic tick(); @(negedge clk); #2; endtask
    task automatic idle(input int n); for (int i = 0; i < n; i++) tick(); endtask
    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0; wr_data = '0;
    endtask
    task automatic do_reset();
        rst_n = 1'b0; idle(2); rst_n = 1'b1; tick();
    endtask

    initial begin
        do_reset();
        chk("R1 reset value", rd_data, 32'h8000_2000);
        chk("R1 reset irq", {31'b0, irq}, 32'h0);
        chk("R1 reset sleep", {31'b0, sleep}, 32'h0);

        irq_en = 1'b1;
        wr(32'hFFFF_FFFD);
        chk("R3 busy after write", {31'b0, rd_data[31]}, 32'h0);
        idle(BC + 2);
        chk("R2 masked store", rd_data, 32'hC00B_67D9);

        wr(32'h0000_0000);
        wr(32'hFFFF_FFFD);               // lands inside busy window
        idle(BC + 2);
        chk("R4 busy write dropped", rd_data, 32'h8000_0000);

        irq_en = 1'b0;
        wr(32'h0000_6000);
        idle(BC + 2);
        chk("R2 field write", rd_data, 32'h8000_6000);

        irq_en = 1'b1;
        tamper = 1'b1; tick(); tamper = 1'b0; idle(2);
        wr(32'hFFFF_FFFD);
        idle(BC + 2);
        chk("R6 R7 locked bits held", rd_data, 32'hC000_6698);

        wr(32'h0000_0002);
        chk("R9 sleep raised", {31'b0, sleep}, 32'h1);
        idle(BC + 2);
        chk("R9 flag back", rd_data, 32'h8000_0002);
        wr(32'hFFFF_FFFD);
        idle(BC + 2);
        chk("R9 writes ignored", rd_data, 32'h8000_0002);

        do_reset();
        chk("R1 second reset", rd_data, 32'h8000_2000);
        wr(32'h000B_0141);
        idle(BC + 2);
        chk("R7 lock cleared by reset", rd_data, 32'h800B_0141);

        idle(3);
        finish_run();
    end
endmodule